// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

This block collects up to 32 active-low interrupt lines and drives two processor interrupt outputs: a normal request line and a fast request line. Each line has its own 7-bit configuration word. The word sets a 5-bit priority, chooses between falling-edge and low-level detection, and picks which of the two outputs the line feeds. Edge events are latched in a pending vector. Level lines count as active only while they are held low, and nothing is stored for them.

For each output, the controller selects the highest-priority active line routed to that output. It raises the output and records the winning line number in a code register. Both stay frozen until software writes the matching acknowledge bit. Reading a code register retires the edge-pending bit of the line it reports. Software can also raise edge-configured lines by writing a set register.

Access is through a simple single-cycle register bus with registered read data. The word offsets are:

| Offset | Register |
|---|---|
| 0x00 | active vector |
| 0x04 | normal code |
| 0x08 | fast code |
| 0x0C | acknowledge |
| 0x10 | software set |
| 0x20 + 4n | configuration word of line n |

Top module: `prio_intc`

## Requirements
- R1: After reset, both outputs are low, both code registers read 0, the active vector reads 0 and every configuration word reads 0.
- R2: The configuration word of line n sits at offset 0x20+4n. Bits 6..2 hold the priority, bit 1 holds the sense (0 = falling edge, 1 = low level) and bit 0 holds the route (0 = normal output, 1 = fast output). Bits above 6 read as 0.
- R3: For an edge-sensed line, a falling edge sets its pending bit, and the bit stays set after the line returns high. A line held low, or a rising edge, sets nothing further.
- R4: A level-sensed line shows as active in the active vector (offset 0x00, bit n) only while it is low. It leaves no stored state once it goes high.
- R5: The route bit decides which output an active line drives. The code register of that output (0x04 normal, 0x08 fast, bits 4..0) reports the line number.
- R6: Among active lines on one output, the numerically lowest priority value wins. When priorities are equal, the lower line number wins.
- R7: Once an output is raised, it and its code register stay unchanged until the matching acknowledge bit is written, even if a better request arrives.
- R8: Writing 1 to bit 0 of offset 0x0C lowers the normal output and clears its code. Writing 1 to bit 1 does the same for the fast output. A new arbitration result may raise that output from the next cycle on. Each bit affects only its own output.
- R9: While an output is raised, reading its code register clears the pending bit of the reported line if that line is edge-sensed. A level-sensed line is unaffected.
- R10: Writing 1 to bit n of offset 0x10 sets line n pending only if line n is edge-sensed. For a level-sensed line the write has no effect. Offset 0x10 always reads 0.
- R11: With an idle output, a falling edge driven between clock edges raises the output on the fourth rising clock edge. A low level raises it on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | NSRC | Active-low interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench targets the following cases:
- **Late higher-priority request.** A better request arrives while an output is already held. A controller that re-arbitrates without waiting for the acknowledge would change the reported code.
- **Equal priorities.** A design using a non-strict compare would report the higher line number instead of the lower one.
- **Software set on a level line.** The bench later switches the same line to edge sense. If the software write had wrongly been stored, the line would then show as pending.
- **Held-low and rising edges on edge lines.** The bench expects no retrigger from either. It also counts the exact cycle at which each output rises, so an extra or missing register stage is caught.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC = 32,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_out,
  output logic            fiq_out
);
  localparam int CW = $clog2(NSRC);
  localparam logic [AW-1:0] A_PEND  = AW'(8'h00);
  localparam logic [AW-1:0] A_ICODE = AW'(8'h04);
  localparam logic [AW-1:0] A_FCODE = AW'(8'h08);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h0C);
  localparam logic [AW-1:0] A_SWSET = AW'(8'h10);
  localparam logic [AW-1:0] A_LVL   = AW'(8'h20);
  localparam logic [AW:0]   A_LEND  = (AW+1)'(32 + 4*NSRC);

  logic [NSRC-1:0] s1, s2, s3, pend, active, sense, route, fall, sw, pend_clr;
  logic [6:0]      lvl [NSRC];
  logic [CW-1:0]   irq_code, fiq_code, irq_win, fiq_win;
  logic [4:0]      irq_best, fiq_best;
  logic            irq_hit, fiq_hit;
  logic [DW-1:0]   rd_mux;

  wire            lvl_sel = ({1'b0, addr} >= {1'b0, A_LVL}) && ({1'b0, addr} < A_LEND);
  wire [AW-1:0]   lvl_off = addr - A_LVL;
  wire [CW-1:0]   lvl_idx = lvl_off[CW+1:2];
  wire            irq_ack = wr_en && addr == A_CTRL && wdata[0];
  wire            fiq_ack = wr_en && addr == A_CTRL && wdata[1];
  wire            irq_rd  = rd_en && addr == A_ICODE && irq_out;
  wire            fiq_rd  = rd_en && addr == A_FCODE && fiq_out;

  assign fall   = s3 & ~s2;
  assign sw     = (wr_en && addr == A_SWSET) ? wdata[NSRC-1:0] : '0;
  assign active = (pend & ~sense) | (~s2 & sense);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      sense[i] = lvl[i][1];
      route[i] = lvl[i][0];
    end
  end

  always_comb begin
    irq_hit = 1'b0; irq_win = '0; irq_best = '0;
    fiq_hit = 1'b0; fiq_win = '0; fiq_best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && !route[i] && (!irq_hit || lvl[i][6:2] < irq_best)) begin
        irq_hit = 1'b1; irq_win = CW'(i); irq_best = lvl[i][6:2];
      end
      if (active[i] && route[i] && (!fiq_hit || lvl[i][6:2] < fiq_best)) begin
        fiq_hit = 1'b1; fiq_win = CW'(i); fiq_best = lvl[i][6:2];
      end
    end
  end

  always_comb begin
    pend_clr = '0;
    if (irq_rd && !sense[irq_code]) pend_clr[irq_code] = 1'b1;
    if (fiq_rd && !sense[fiq_code]) pend_clr[fiq_code] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_PEND)       rd_mux = DW'(active);
    else if (addr == A_ICODE) rd_mux = DW'(irq_code);
    else if (addr == A_FCODE) rd_mux = DW'(fiq_code);
    else if (lvl_sel)         rd_mux = DW'(lvl[lvl_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
      pend <= '0;
      rdata <= '0;
      irq_out <= 1'b0; irq_code <= '0;
      fiq_out <= 1'b0; fiq_code <= '0;
      for (int i = 0; i < NSRC; i++) lvl[i] <= '0;
    end else begin
      s1 <= src_n; s2 <= s1; s3 <= s2;
      pend <= (pend & ~pend_clr) | ((fall | sw) & ~sense);
      if (rd_en) rdata <= rd_mux;
      if (wr_en && lvl_sel) lvl[lvl_idx] <= wdata[6:0];
      if (irq_ack) begin
        irq_out <= 1'b0; irq_code <= '0;
      end else if (!irq_out && irq_hit) begin
        irq_out <= 1'b1; irq_code <= irq_win;
      end
      if (fiq_ack) begin
        fiq_out <= 1'b0; fiq_code <= '0;
      end else if (!fiq_out && fiq_hit) begin
        fiq_out <= 1'b1; fiq_code <= fiq_win;
      end
    end
  end

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !irq_ack |=> irq_out && $stable(irq_code));
  assert_fiq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out && !fiq_ack |=> fiq_out && $stable(fiq_code));
  assert_irq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_out && irq_code == '0);
  assert_fiq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_ack |=> !fiq_out && fiq_code == '0);
  assert_edge_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |(fall & ~sense) |=> ($past(fall & ~sense) & ~pend) == '0);
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_n = '1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out, fiq_out;
  int checks = 0, failures = 0;
  logic [4:0] mprio [32];
  logic       mroute [32];

  prio_intc uut (.clk(clk), .rst_n(rst_n), .src_n(src_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic int winner(input logic [31:0] p, input logic rt);
    int w = -1;
    for (int i = 0; i < 32; i++)
      if (p[i] && mroute[i] == rt && (w < 0 || mprio[i] < mprio[w])) w = i;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, mp;
    int w;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    chk("R1 fiq_out", {31'b0, fiq_out}, 0);
    rd(8'h00, d); chk("R1 active", d, 0);
    rd(8'h04, d); chk("R1 irq code", d, 0);
    rd(8'h08, d); chk("R1 fiq code", d, 0);
    rd(8'h34, d); chk("R1 cfg5", d, 0);

    // R2 field width
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, d); chk("R2 cfg3 readback", d, 32'h7F);
    wr(8'h2C, 0);

    // R11/R3 edge latency, held low and rising edge ignored
    wr(8'h3C, 32'h10);
    src_n[7] = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R11 edge not yet", {31'b0, irq_out}, 0);
    @(posedge clk);
    #1 chk("R11 edge on fourth", {31'b0, irq_out}, 1);
    @(negedge clk);
    chk("R5 fiq idle", {31'b0, fiq_out}, 0);
    rd(8'h04, d); chk("R5 irq code 7", d, 7);
    rd(8'h00, d); chk("R9 edge pend cleared", d & 32'h80, 0);
    chk("R7 still raised", {31'b0, irq_out}, 1);
    wr(8'h0C, 1);
    chk("R8 irq lowered", {31'b0, irq_out}, 0);
    rd(8'h04, d); chk("R8 irq code cleared", d, 0);
    tick(3);
    chk("R3 held low no retrigger", {31'b0, irq_out}, 0);
    src_n[7] = 1'b1;
    tick(5);
    rd(8'h00, d); chk("R3 rising ignored", d, 0);
    chk("R3 rising no output", {31'b0, irq_out}, 0);

    // R3 short pulse stays pending
    wr(8'h98, 32'h00);
    src_n[30] = 1'b0; tick(2); src_n[30] = 1'b1;
    tick(5);
    rd(8'h00, d); chk("R3 pulse latched", d, 32'h4000_0000);
    rd(8'h04, d); chk("R3 pulse code", d, 30);
    wr(8'h0C, 1); tick(1);

    // R11/R4/R9 level source on fast output
    wr(8'h50, 32'h0B);
    src_n[12] = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R11 level not yet", {31'b0, fiq_out}, 0);
    @(posedge clk);
    #1 chk("R11 level on third", {31'b0, fiq_out}, 1);
    @(negedge clk);
    chk("R5 irq idle", {31'b0, irq_out}, 0);
    rd(8'h00, d); chk("R4 level active", d, 32'h1000);
    rd(8'h08, d); chk("R5 fiq code 12", d, 12);
    rd(8'h00, d); chk("R9 level not cleared", d, 32'h1000);
    src_n[12] = 1'b1;
    tick(3);
    rd(8'h00, d); chk("R4 level gone", d, 0);
    wr(8'h0C, 1); tick(1);
    chk("R8 bit0 leaves fiq", {31'b0, fiq_out}, 1);
    wr(8'h0C, 2); tick(1);
    chk("R8 fiq lowered", {31'b0, fiq_out}, 0);

    // R7/R6 freeze against better late request
    wr(8'h44, 32'h28); wr(8'h28, 32'h04);
    wr(8'h10, 32'h200); tick(1);
    chk("R7 raised", {31'b0, irq_out}, 1);
    wr(8'h10, 32'h4); tick(1);
    rd(8'h04, d); chk("R7 frozen code", d, 9);
    wr(8'h0C, 1); tick(1);
    rd(8'h04, d); chk("R6 better next", d, 2);
    wr(8'h0C, 1); tick(1);
    chk("R8 all served", {31'b0, irq_out}, 0);

    // R6 tie
    wr(8'h70, 32'h0C); wr(8'h34, 32'h0C);
    wr(8'h10, 32'h0010_0020); tick(1);
    rd(8'h04, d); chk("R6 tie lower index", d, 5);
    wr(8'h0C, 1); tick(1);
    rd(8'h04, d); chk("R6 tie second", d, 20);
    wr(8'h0C, 1); tick(1);

    // R10 software set on level source
    wr(8'h5C, 32'h02);
    wr(8'h10, 32'h8000); tick(2);
    chk("R10 level no output", {31'b0, irq_out}, 0);
    wr(8'h5C, 32'h00); tick(2);
    rd(8'h00, d); chk("R10 level set not stored", d, 0);
    chk("R10 no output after edge switch", {31'b0, irq_out}, 0);
    rd(8'h10, d); chk("R10 reads zero", d, 0);

    // Random rounds, edge sources, software set
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < 32; i++) begin
        mprio[i] = 5'($urandom);
        mroute[i] = 1'($urandom);
        wr(8'(32 + 4*i), {25'b0, mprio[i], 1'b0, mroute[i]});
      end
      mp = $urandom;
      wr(8'h10, mp);
      for (int k = 0; k < 33; k++) begin
        tick(1);
        w = winner(mp, 1'b0);
        chk("R6 random irq level", {31'b0, irq_out}, {31'b0, (w >= 0)});
        if (w >= 0) begin
          rd(8'h04, d); chk("R6 random irq code", d, w);
          mp[w] = 1'b0;
          wr(8'h0C, 1);
        end
        w = winner(mp, 1'b1);
        chk("R5 random fiq level", {31'b0, fiq_out}, {31'b0, (w >= 0)});
        if (w >= 0) begin
          rd(8'h08, d); chk("R5 random fiq code", d, w);
          mp[w] = 1'b0;
          wr(8'h0C, 2);
        end
        if (mp == 0) break;
      end
      tick(1);
      rd(8'h00, d); chk("R9 random all retired", d, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule